// File: doc/BRIEF.md
# Data Line Refill Buffers with Store Merge

This block holds data cache refills that are waiting for external memory. It has a small set of line-sized buffers, two by default, each 32 bytes wide. A load miss or a store miss claims a free buffer for a line address. External memory then returns the line as ascending 64-bit beats, and the buffer gathers them. While the refill is outstanding, stores to the same line are merged into the buffer at byte granularity. A stored byte always wins over the byte that memory returns for the same position, whether the store came before the beat, after it, or in the same cycle.

When the last beat has been taken, the complete line is presented for one cycle. For a cacheable refill it goes to the cache RAM as a single write. For a buffer claimed by an uncached burst read, the line is returned to the requester and is never written to the cache. Stores never merge into an uncached buffer. The buffer becomes free in the following cycle. If every buffer is busy, a new claim is refused.

Top module: `linefill_merge`

## Requirements
- R1: After reset every buffer is free: `alloc_ready` is 1, `st_hit` is 0, and both `cache_wr_valid` and `nc_rd_valid` are 0.
- R2: A claim is accepted in a cycle where `alloc_valid` and `alloc_ready` are both 1. It takes the lowest-numbered free buffer and reports that number on `alloc_id` in the same cycle. The line address is `alloc_addr` with its low 5 bits ignored.
- R3: While every buffer is busy, `alloc_ready` is 0 and a claim has no effect. The refused line address never appears on a completion.
- R4: Fill beat k (k = 0..3, taken when `fill_valid` is 1, in order, for buffer `fill_id`) supplies line bytes 8k..8k+7, with byte lane j on `fill_data[8j+7:8j]`. In the cycle after the edge that takes beat 3, the buffer presents its line on `cpl_data`, with byte b at bits 8b+7:8b, and its line-aligned address on `cpl_addr`.
- R5: A store (`st_valid`) whose line matches a cacheable buffer that is still collecting beats raises `st_hit` in the same cycle. It writes the lanes enabled in `st_be` of beat `st_addr[4:3]`, and a later fill beat never overwrites those bytes.
- R6: When a store and a fill beat reach the same bytes in the same cycle, the completed line holds the store bytes, while the beat's remaining lanes hold fill data.
- R7: A store whose line matches no collecting buffer, or matches only an uncached buffer, gives `st_hit` = 0 and changes no completed line.
- R8: A cacheable completion raises `cache_wr_valid` and an uncached completion raises `nc_rd_valid`. The two are never 1 together, and the buffer can be claimed again in the next cycle.
- R9: A store to a beat that has already arrived still replaces those bytes, as long as the line has not yet completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Claim a buffer for a refill or an uncached burst |
| alloc_addr | input | 32 | Byte address inside the line to fetch |
| alloc_nc | input | 1 | 1 = uncached burst read, 0 = cache refill |
| alloc_ready | output | 1 | At least one buffer is free |
| alloc_id | output | 1 | Buffer chosen for the claim |
| st_valid | input | 1 | Missed store offered for merging |
| st_addr | input | 32 | Store byte address; bits 4:3 select the beat |
| st_data | input | 64 | Store data, lane j on bits 8j+7:8j |
| st_be | input | 8 | Store byte enables per lane |
| st_hit | output | 1 | The store was merged into a buffer |
| fill_valid | input | 1 | A returned beat is present |
| fill_id | input | 1 | Buffer the beat belongs to |
| fill_data | input | 64 | Beat data |
| cache_wr_valid | output | 1 | Completed line to be written into the cache |
| nc_rd_valid | output | 1 | Completed line returned for an uncached read |
| cpl_addr | output | 32 | Line-aligned address of the completed line |
| cpl_data | output | 256 | Completed merged line |

## Verification
The race of interest is a merging store and a returning beat that land on the same beat of the same buffer in one clock. The bench drives both in one cycle, with the store enabling only half of the lanes. It then judges the completed line byte by byte: store bytes must sit in the enabled lanes and memory bytes in the others. A second overlap covers the claim path. Both buffers are held busy while a third claim is offered. That claim must see `alloc_ready` low, and the completions that follow must carry only the two accepted line addresses.

// File: rtl/linefill_pkg.sv
package linefill_pkg;

   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_FILL = 2'd1,
      SLOT_DONE = 2'd2
   } slot_state_e;

endpackage

// File: rtl/linefill_pick.sv
module linefill_pick #(
   parameter  int N  = 2,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  gnt
);

   if (N == 1) begin : g_single
      assign any = req[0];
      assign idx = '0;
      assign gnt = req;
   end else begin : g_multi
      // lowest set index wins
      always_comb begin
         any = 1'b0;
         idx = '0;
         gnt = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               any = 1'b1;
               idx = IW'(i);
               gnt = N'(1) << i;
            end
         end
      end
   end

endmodule

// File: rtl/linefill_slot.sv
module linefill_slot
   import linefill_pkg::*;
#(
   parameter  int LINE_BYTES = 32,
   parameter  int BEAT_BYTES = 8,
   parameter  int ADDR_W     = 32,
   localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
   localparam int BEAT_W     = $clog2(BEATS),
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int TAG_W      = ADDR_W - OFF_W,
   localparam int BEAT_BITS  = BEAT_BYTES * 8,
   localparam int LINE_BITS  = LINE_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_i,
   input  logic [TAG_W-1:0]      alloc_tag_i,
   input  logic                  alloc_nc_i,
   input  logic                  st_en_i,
   input  logic [BEAT_W-1:0]     st_beat_i,
   input  logic [BEAT_BITS-1:0]  st_data_i,
   input  logic [BEAT_BYTES-1:0] st_be_i,
   input  logic                  fill_en_i,
   input  logic [BEAT_BITS-1:0]  fill_data_i,
   output slot_state_e           state_o,
   output logic [TAG_W-1:0]      tag_o,
   output logic                  nc_o,
   output logic [LINE_BITS-1:0]  line_o
);

   slot_state_e       state_q;
   logic [BEAT_W-1:0] cnt_q;
   logic [TAG_W-1:0]  tag_q;
   logic              nc_q;
   logic              st_go;
   logic              fill_go;
   logic              last_beat;

   assign st_go     = st_en_i   && (state_q == SLOT_FILL);
   assign fill_go   = fill_en_i && (state_q == SLOT_FILL);
   assign last_beat = (cnt_q == BEAT_W'(BEATS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SLOT_IDLE;
         cnt_q   <= '0;
         tag_q   <= '0;
         nc_q    <= 1'b0;
      end else begin
         case (state_q)
            SLOT_IDLE: if (alloc_i) begin
               state_q <= SLOT_FILL;
               cnt_q   <= '0;
               tag_q   <= alloc_tag_i;
               nc_q    <= alloc_nc_i;
            end
            SLOT_FILL: if (fill_go) begin
               cnt_q <= cnt_q + 1'b1;
               if (last_beat) state_q <= SLOT_DONE;
            end
            default: state_q <= SLOT_IDLE;
         endcase
      end
   end

   // one register and one "written by store" flag per byte of the line
   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
      localparam int BI = b / BEAT_BYTES;
      localparam int LN = b % BEAT_BYTES;
      logic [7:0] q;
      logic       owned;
      logic       st_sel;
      logic       fill_sel;

      assign st_sel   = st_go && (st_beat_i == BEAT_W'(BI)) && st_be_i[LN];
      assign fill_sel = fill_go && (cnt_q == BEAT_W'(BI)) && !owned && !st_sel;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q     <= '0;
            owned <= 1'b0;
         end else if (alloc_i && state_q == SLOT_IDLE) begin
            owned <= 1'b0;
         end else if (st_sel) begin
            q     <= st_data_i[LN*8 +: 8];
            owned <= 1'b1;
         end else if (fill_sel) begin
            q     <= fill_data_i[LN*8 +: 8];
         end
      end

      assign line_o[b*8 +: 8] = q;
   end

   assign state_o = state_q;
   assign tag_o   = tag_q;
   assign nc_o    = nc_q;

endmodule

// File: rtl/linefill_merge.sv
module linefill_merge
   import linefill_pkg::*;
#(
   parameter  int NUM_BUF    = 2,
   parameter  int LINE_BYTES = 32,
   parameter  int BEAT_BYTES = 8,
   parameter  int ADDR_W     = 32,
   localparam int ID_W       = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
   localparam int BEAT_BITS  = BEAT_BYTES * 8,
   localparam int LINE_BITS  = LINE_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_valid,
   input  logic [ADDR_W-1:0]     alloc_addr,
   input  logic                  alloc_nc,
   output logic                  alloc_ready,
   output logic [ID_W-1:0]       alloc_id,
   input  logic                  st_valid,
   input  logic [ADDR_W-1:0]     st_addr,
   input  logic [BEAT_BITS-1:0]  st_data,
   input  logic [BEAT_BYTES-1:0] st_be,
   output logic                  st_hit,
   input  logic                  fill_valid,
   input  logic [ID_W-1:0]       fill_id,
   input  logic [BEAT_BITS-1:0]  fill_data,
   output logic                  cache_wr_valid,
   output logic                  nc_rd_valid,
   output logic [ADDR_W-1:0]     cpl_addr,
   output logic [LINE_BITS-1:0]  cpl_data
);

   localparam int BEATS    = LINE_BYTES / BEAT_BYTES;
   localparam int BEAT_W   = $clog2(BEATS);
   localparam int OFF_W    = $clog2(LINE_BYTES);
   localparam int LANE_W   = $clog2(BEAT_BYTES);
   localparam int TAG_W    = ADDR_W - OFF_W;

   if (NUM_BUF < 1 || BEAT_BYTES < 2 || BEATS < 2 ||
       (1 << OFF_W) != LINE_BYTES || (1 << LANE_W) != BEAT_BYTES ||
       ADDR_W <= OFF_W) begin : g_bad_cfg
      $fatal(1, "linefill_merge: unsupported line/beat/buffer geometry");
   end

   slot_state_e          slot_state [NUM_BUF];
   logic [TAG_W-1:0]     slot_tag   [NUM_BUF];
   logic                 slot_nc    [NUM_BUF];
   logic [LINE_BITS-1:0] slot_line  [NUM_BUF];

   logic [NUM_BUF-1:0] free_vec, free_gnt;
   logic [NUM_BUF-1:0] match_vec, match_gnt;
   logic [NUM_BUF-1:0] done_vec, done_gnt;
   logic               match_any, done_any;
   logic [ID_W-1:0]    match_idx, done_idx;

   logic [TAG_W-1:0]   st_tag;
   logic [BEAT_W-1:0]  st_beat;
   logic               unused_bits;

   assign st_tag      = st_addr[ADDR_W-1:OFF_W];
   assign st_beat     = st_addr[OFF_W-1:LANE_W];
   assign unused_bits = ^{alloc_addr[OFF_W-1:0], st_addr[LANE_W-1:0],
                          match_idx, done_idx};

   for (genvar i = 0; i < NUM_BUF; i++) begin : g_vec
      assign free_vec[i]  = (slot_state[i] == SLOT_IDLE);
      assign done_vec[i]  = (slot_state[i] == SLOT_DONE);
      assign match_vec[i] = st_valid && (slot_state[i] == SLOT_FILL) &&
                            !slot_nc[i] && (slot_tag[i] == st_tag);
   end

   linefill_pick #(.N(NUM_BUF)) u_pick_free (
      .req (free_vec),
      .any (alloc_ready),
      .idx (alloc_id),
      .gnt (free_gnt)
   );

   linefill_pick #(.N(NUM_BUF)) u_pick_store (
      .req (match_vec),
      .any (match_any),
      .idx (match_idx),
      .gnt (match_gnt)
   );

   linefill_pick #(.N(NUM_BUF)) u_pick_done (
      .req (done_vec),
      .any (done_any),
      .idx (done_idx),
      .gnt (done_gnt)
   );

   assign st_hit = match_any;

   for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
      linefill_slot #(
         .LINE_BYTES (LINE_BYTES),
         .BEAT_BYTES (BEAT_BYTES),
         .ADDR_W     (ADDR_W)
      ) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .alloc_i     (alloc_valid && free_gnt[i]),
         .alloc_tag_i (alloc_addr[ADDR_W-1:OFF_W]),
         .alloc_nc_i  (alloc_nc),
         .st_en_i     (match_gnt[i]),
         .st_beat_i   (st_beat),
         .st_data_i   (st_data),
         .st_be_i     (st_be),
         .fill_en_i   (fill_valid && (fill_id == ID_W'(i))),
         .fill_data_i (fill_data),
         .state_o     (slot_state[i]),
         .tag_o       (slot_tag[i]),
         .nc_o        (slot_nc[i]),
         .line_o      (slot_line[i])
      );
   end

   logic             cpl_nc;
   logic [TAG_W-1:0] cpl_tag;

   always_comb begin
      cpl_nc   = 1'b0;
      cpl_tag  = '0;
      cpl_data = '0;
      for (int i = 0; i < NUM_BUF; i++) begin
         if (done_gnt[i]) begin
            cpl_nc   = slot_nc[i];
            cpl_tag  = slot_tag[i];
            cpl_data = slot_line[i];
         end
      end
   end

   assign cache_wr_valid = done_any && !cpl_nc;
   assign nc_rd_valid    = done_any &&  cpl_nc;
   assign cpl_addr       = {cpl_tag, {OFF_W{1'b0}}};

endmodule

// File: rtl/linefill_merge_chk.sv
module linefill_merge_chk #(
   parameter int NUM_BUF = 2
) (
   input logic clk,
   input logic rst_n,
   input logic alloc_valid,
   input logic alloc_ready,
   input logic st_hit,
   input logic fill_valid,
   input logic cache_wr_valid,
   input logic nc_rd_valid
);

   localparam int OW = $clog2(NUM_BUF + 1) + 1;

   logic [OW-1:0] occ_q;
   logic          cpl;

   assign cpl = cache_wr_valid || nc_rd_valid;

   // independent count of claimed buffers
   always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= '0;
      else if ((alloc_valid && alloc_ready) && !cpl) occ_q <= occ_q + 1'b1;
      else if (!(alloc_valid && alloc_ready) && cpl) occ_q <= occ_q - 1'b1;
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OW'(NUM_BUF));

   p_ready_tracks_occ_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_ready == (occ_q < OW'(NUM_BUF)));

   p_cpl_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cache_wr_valid && nc_rd_valid));

   p_cpl_after_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cpl |-> $past(fill_valid));

   p_free_after_cpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpl |=> alloc_ready);

   p_hit_needs_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st_hit |-> (occ_q != '0));

endmodule

bind linefill_merge linefill_merge_chk #(.NUM_BUF(NUM_BUF)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .alloc_valid    (alloc_valid),
   .alloc_ready    (alloc_ready),
   .st_hit         (st_hit),
   .fill_valid     (fill_valid),
   .cache_wr_valid (cache_wr_valid),
   .nc_rd_valid    (nc_rd_valid)
);

// File: tb/linefill_merge_tb.sv
`timescale 1ns/1ps
module linefill_merge_tb;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         alloc_valid, alloc_nc, alloc_ready;
   logic [31:0]  alloc_addr;
   logic [0:0]   alloc_id;
   logic         st_valid, st_hit;
   logic [31:0]  st_addr;
   logic [63:0]  st_data;
   logic [7:0]   st_be;
   logic         fill_valid;
   logic [0:0]   fill_id;
   logic [63:0]  fill_data;
   logic         cache_wr_valid, nc_rd_valid;
   logic [31:0]  cpl_addr;
   logic [255:0] cpl_data;

   int  n_checks = 0;
   int  n_err    = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   linefill_merge u_dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_nc(alloc_nc),
      .alloc_ready(alloc_ready), .alloc_id(alloc_id),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
      .st_hit(st_hit),
      .fill_valid(fill_valid), .fill_id(fill_id), .fill_data(fill_data),
      .cache_wr_valid(cache_wr_valid), .nc_rd_valid(nc_rd_valid),
      .cpl_addr(cpl_addr), .cpl_data(cpl_data)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [255:0] mk_line(input logic [7:0] base);
      logic [255:0] l;
      for (int b = 0; b < 32; b++) l[b*8 +: 8] = base + 8'(b);
      return l;
   endfunction

   function automatic logic [255:0] overlay(input logic [255:0] l, input int beat,
                                            input logic [63:0] d, input logic [7:0] be);
      for (int j = 0; j < 8; j++)
         if (be[j]) l[beat*64 + j*8 +: 8] = d[j*8 +: 8];
      return l;
   endfunction

   task automatic do_alloc(input logic [31:0] a, input logic nc, input bit exp_rdy,
                           input logic [0:0] exp_id, input string rq);
      alloc_valid = 1'b1; alloc_addr = a; alloc_nc = nc;
      #1;
      chk(alloc_ready == exp_rdy, rq, "alloc_ready", 256'(alloc_ready), 256'(exp_rdy));
      if (exp_rdy) chk(alloc_id == exp_id, rq, "alloc_id", 256'(alloc_id), 256'(exp_id));
      tick();
      alloc_valid = 1'b0;
   endtask

   task automatic do_store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be,
                           input bit exp_hit, input string rq);
      st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
      #1;
      chk(st_hit == exp_hit, rq, "st_hit", 256'(st_hit), 256'(exp_hit));
      tick();
      st_valid = 1'b0;
   endtask

   task automatic do_beat(input logic [0:0] id, input logic [63:0] d);
      fill_valid = 1'b1; fill_id = id; fill_data = d;
      tick();
      fill_valid = 1'b0;
   endtask

   task automatic check_cpl(input bit nc, input logic [31:0] a, input logic [255:0] l,
                            input string rq);
      chk(cache_wr_valid == !nc, rq, "cache_wr_valid", 256'(cache_wr_valid), 256'(!nc));
      chk(nc_rd_valid == nc, rq, "nc_rd_valid", 256'(nc_rd_valid), 256'(nc));
      chk(cpl_addr == a, rq, "cpl_addr", 256'(cpl_addr), 256'(a));
      chk(cpl_data == l, rq, "cpl_data", cpl_data, l);
   endtask

   // R1
   task automatic t_reset();
      chk(alloc_ready == 1'b1, "R1", "alloc_ready", 256'(alloc_ready), 256'(1));
      chk(st_hit == 1'b0, "R1", "st_hit", 256'(st_hit), 256'(0));
      chk(cache_wr_valid == 1'b0, "R1", "cache_wr_valid", 256'(cache_wr_valid), 256'(0));
      chk(nc_rd_valid == 1'b0, "R1", "nc_rd_valid", 256'(nc_rd_valid), 256'(0));
   endtask

   // R2, R4, R7, R8: plain refill, stray store elsewhere
   task automatic t_plain_fill();
      logic [255:0] l = mk_line(8'h10);
      do_alloc(32'h1000_0057, 1'b0, 1'b1, 1'b0, "R2");
      do_beat(1'b0, l[63:0]);
      do_store(32'h2000_0008, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, "R7");
      for (int k = 1; k < 4; k++) do_beat(1'b0, l[k*64 +: 64]);
      check_cpl(1'b0, 32'h1000_0040, l, "R4");
      tick();
      chk(alloc_ready == 1'b1, "R8", "alloc_ready after cpl", 256'(alloc_ready), 256'(1));
      chk(cache_wr_valid == 1'b0, "R8", "cache_wr_valid drop", 256'(cache_wr_valid), 256'(0));
   endtask

   // R5, R9: stores before and after their beats arrive
   task automatic t_merge();
      logic [255:0] l = mk_line(8'h40);
      logic [255:0] e;
      do_alloc(32'h3000_0100, 1'b0, 1'b1, 1'b0, "R2");
      do_store(32'h3000_0108, 64'hCAFE_BABE_DEAD_BEEF, 8'h0F, 1'b1, "R5");
      do_beat(1'b0, l[63:0]);
      do_beat(1'b0, l[127:64]);
      do_store(32'h3000_0100, 64'h7700_0000_0000_0000, 8'h80, 1'b1, "R9");
      do_beat(1'b0, l[191:128]);
      do_beat(1'b0, l[255:192]);
      e = overlay(l, 1, 64'hCAFE_BABE_DEAD_BEEF, 8'h0F);
      e = overlay(e, 0, 64'h7700_0000_0000_0000, 8'h80);
      check_cpl(1'b0, 32'h3000_0100, e, "R5");
      tick();
   endtask

   // R6: store and beat on the same bytes in one cycle
   task automatic t_collision();
      logic [255:0] l = mk_line(8'h80);
      logic [255:0] e;
      do_alloc(32'h4000_0020, 1'b0, 1'b1, 1'b0, "R2");
      fill_valid = 1'b1; fill_id = 1'b0; fill_data = l[63:0];
      st_valid = 1'b1; st_addr = 32'h4000_0020; st_data = 64'hA5A5_A5A5_5A5A_5A5A;
      st_be = 8'h0F;
      #1;
      chk(st_hit == 1'b1, "R6", "st_hit with beat", 256'(st_hit), 256'(1));
      tick();
      fill_valid = 1'b0; st_valid = 1'b0;
      for (int k = 1; k < 4; k++) do_beat(1'b0, l[k*64 +: 64]);
      e = overlay(l, 0, 64'hA5A5_A5A5_5A5A_5A5A, 8'h0F);
      check_cpl(1'b0, 32'h4000_0020, e, "R6");
      tick();
   endtask

   // R2, R3: both buffers busy, third claim refused
   task automatic t_full();
      logic [255:0] la = mk_line(8'h01);
      logic [255:0] lb = mk_line(8'hC0);
      do_alloc(32'h5000_0000, 1'b0, 1'b1, 1'b0, "R2");
      do_alloc(32'h5000_0200, 1'b0, 1'b1, 1'b1, "R2");
      do_alloc(32'h5000_0400, 1'b0, 1'b0, 1'b0, "R3");
      for (int k = 0; k < 4; k++) do_beat(1'b1, lb[k*64 +: 64]);
      check_cpl(1'b0, 32'h5000_0200, lb, "R3");
      tick();
      chk(alloc_ready == 1'b1, "R3", "ready after one free", 256'(alloc_ready), 256'(1));
      for (int k = 0; k < 4; k++) do_beat(1'b0, la[k*64 +: 64]);
      check_cpl(1'b0, 32'h5000_0000, la, "R3");
      tick();
      chk(cache_wr_valid == 1'b0 && nc_rd_valid == 1'b0, "R3", "no refused line cpl",
          256'(cache_wr_valid | nc_rd_valid), 256'(0));
   endtask

   // R7, R8: uncached burst ignores stores and bypasses cache write
   task automatic t_uncached();
      logic [255:0] l = mk_line(8'hE0);
      do_alloc(32'h6000_0060, 1'b1, 1'b1, 1'b0, "R2");
      do_store(32'h6000_0070, 64'h1111_2222_3333_4444, 8'hFF, 1'b0, "R7");
      for (int k = 0; k < 4; k++) do_beat(1'b0, l[k*64 +: 64]);
      check_cpl(1'b1, 32'h6000_0060, l, "R8");
      tick();
      chk(nc_rd_valid == 1'b0, "R8", "nc_rd_valid drop", 256'(nc_rd_valid), 256'(0));
   endtask

   initial begin
      rst_n = 1'b0;
      alloc_valid = 1'b0; alloc_addr = '0; alloc_nc = 1'b0;
      st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
      fill_valid = 1'b0; fill_id = '0; fill_data = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_plain_fill();
      t_merge();
      t_collision();
      t_full();
      t_uncached();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

endmodule